// File: doc/BRIEF.md
# Dual-Port Serial Controller with Local Loopback

This block is the register-side model of a two-port asynchronous serial controller. A processor reaches it over a simple byte-wide register bus with separate write and read strobes. Each port has a control register, a command register, a status register, a transmit holding register and a three-entry receive FIFO. The serial shifter is modelled only by its timing: after a configurable delay, an internal counter signals that the character has left the transmitter.

A port whose control register selects local loopback does not start the shifter. Instead, each accepted transmit byte goes straight into that port's own receive FIFO, so software can test the receive path without a line. Receive-ready and transmit-ready events from both ports are gathered in one interrupt status register. An interrupt mask qualifies them before they drive a single interrupt output. A read-only input port shows the carrier-detect pin in active-low form.

Register map (4-bit address): port A uses 0 to 2 and port B uses 4 to 6. Within a port, offset 0 is control, offset 1 is status on read and command on write, and offset 2 is the receive FIFO on read and the transmit holding register on write. Address 8 reads interrupt status and writes the interrupt mask. Address 9 reads the input port. Address 10 reads the mask back. Status bits are: 0 receiver-ready, 1 FIFO-full, 2 transmitter-ready, 3 transmitter-empty. Interrupt status and mask bits are: 0 port A transmit-ready, 1 port A receive-ready, 4 port B transmit-ready, 5 port B receive-ready.

Top module: `dual_uart_lb`

## Requirements
- R1: After reset both transmitters are disabled, both status registers and the interrupt status register read 0x00, and the interrupt output and both DMA request outputs are low.
- R2: A command write with bit 2 set (and bit 3 clear) enables the port's transmitter and sets transmitter-ready and transmitter-empty, so status reads 0x0C when the FIFO is empty.
- R3: A command write with bit 4 set raises that port's DMA request output. A command write with bit 3 set disables the transmitter and clears transmitter-ready, transmitter-empty and the DMA request, and it wins over bit 2.
- R4: With the transmitter enabled and control bits 7:6 not equal to binary 10, a write to the transmit holding register clears transmitter-ready, transmitter-empty and the port's transmit bit in interrupt status (bit 0 for A, bit 4 for B). Exactly TX_DELAY clock edges after the write edge, transmitter-ready and that interrupt status bit are set again, while transmitter-empty stays clear.
- R5: At transmit completion the interrupt output rises only if the port's transmit mask bit is set and its transmitter is still enabled.
- R6: With control bits 7:6 equal to binary 10 and the transmitter enabled, a transmit write stores the byte in the port's own receive FIFO and sets receiver-ready and the port's receive bit in interrupt status (bit 1 for A, bit 5 for B). It leaves the transmitter flags unchanged. The interrupt output is raised only if the receive mask bit is set.
- R7: The receive FIFO holds three bytes. FIFO-full is set when a store makes the write pointer meet the read pointer, stays set until the FIFO is emptied by reads, and a loopback byte written while it is set is dropped.
- R8: A read of a port's receive register returns the oldest stored byte on rdata the cycle after the read strobe and advances the read pointer, giving first-in first-out order.
- R9: A receive read that empties the FIFO clears receiver-ready, FIFO-full, the port's receive interrupt status bit and the interrupt output. A receive read that leaves bytes stored drives the interrupt output high.
- R10: A transmit holding register write while the transmitter is disabled is ignored in both normal and loopback modes: status, interrupt status and FIFO contents do not change.
- R11: The input port at address 9 reads 0xFE while the carrier input is high and 0xFF while it is low.
- R12: Any accepted transmit write drops the interrupt output, unless that same write raises it under R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| carrier | input | 1 | Carrier detect, high when asserted |
| rdata | output | 8 | Read data, registered one cycle after re |
| irq | output | 1 | Merged interrupt output |
| drq | output | 2 | DMA request per port, bit 0 port A |

## Verification
The hardest state to reach is a full FIFO after a partial read. In that state the full flag must stay set with two bytes left, and the interrupt must be held high even when the receive mask is clear. Loopback gives a direct path there: the stimulus pushes four bytes through the transmit register, so the fourth must be dropped, and then drains the FIFO one read at a time, checking order, status and the interrupt after each read. This sequence is swept over both ports and all four settings of each port's two mask bits. The transmit-completion edge is pinned exactly by watching the interrupt output cycle by cycle.

// File: rtl/dual_uart_lb.sv
module dual_uart_lb #(
  parameter int TX_DELAY   = 16,
  parameter int FIFO_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       re,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       carrier,
  output logic [7:0] rdata,
  output logic       irq,
  output logic [1:0] drq
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(TX_DELAY + 1);

  logic [7:0]    ctrl [2];
  logic [7:0]    fifo [2][FIFO_DEPTH];
  logic [PW-1:0] rp [2];
  logic [PW-1:0] wp [2];
  logic [CW-1:0] cnt [2];
  logic [PW-1:0] rp_nx [2];
  logic [PW-1:0] wp_nx [2];
  logic [1:0] txen, txrdy, txemp, rxrdy, full, isr_tx, isr_rx;
  logic [7:0] mask;
  logic [1:0] wr_ctl, wr_cmd, wr_dat, rd_dat, loop, acc, pop, last, done, dis, en;
  logic [1:0] tx_irq, lb_irq;
  logic       irq_set, irq_clr;
  logic [7:0] isr_val;

  assign isr_val = {2'b00, isr_rx[1], isr_tx[1], 2'b00, isr_rx[0], isr_tx[0]};

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      wr_ctl[p] = we && !addr[3] && addr[2] == 1'(p) && addr[1:0] == 2'd0;
      wr_cmd[p] = we && !addr[3] && addr[2] == 1'(p) && addr[1:0] == 2'd1;
      wr_dat[p] = we && !addr[3] && addr[2] == 1'(p) && addr[1:0] == 2'd2;
      rd_dat[p] = re && !addr[3] && addr[2] == 1'(p) && addr[1:0] == 2'd2;
      dis[p]    = wr_cmd[p] && wdata[3];
      en[p]     = wr_cmd[p] && wdata[2] && !wdata[3];
      loop[p]   = ctrl[p][7:6] == 2'b10;
      acc[p]    = wr_dat[p] && txen[p];
      pop[p]    = rd_dat[p] && rxrdy[p];
      rp_nx[p]  = (rp[p] == PW'(FIFO_DEPTH - 1)) ? '0 : rp[p] + 1'b1;
      wp_nx[p]  = (wp[p] == PW'(FIFO_DEPTH - 1)) ? '0 : wp[p] + 1'b1;
      last[p]   = pop[p] && rp_nx[p] == wp[p];
      done[p]   = cnt[p] == CW'(1) && !(acc[p] && !loop[p]);
      tx_irq[p] = done[p] && !dis[p] && mask[p*4];
      lb_irq[p] = acc[p] && loop[p] && mask[p*4+1];
    end
    irq_set = |tx_irq || |lb_irq || |(pop & ~last);
    irq_clr = |acc || |last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        ctrl[p] <= '0;
        rp[p]   <= '0;
        wp[p]   <= '0;
        cnt[p]  <= '0;
        for (int i = 0; i < FIFO_DEPTH; i++) fifo[p][i] <= '0;
      end
      {txen, txrdy, txemp, rxrdy, full, isr_tx, isr_rx, drq} <= '0;
      mask  <= '0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (wr_ctl[p]) ctrl[p] <= wdata;
        if (acc[p] && !loop[p]) begin
          txrdy[p]  <= 1'b0;
          txemp[p]  <= 1'b0;
          isr_tx[p] <= 1'b0;
          cnt[p]    <= CW'(TX_DELAY);
        end else if (cnt[p] != '0) begin
          cnt[p] <= cnt[p] - 1'b1;
          if (done[p]) begin
            txrdy[p]  <= 1'b1;
            isr_tx[p] <= 1'b1;
          end
        end
        if (acc[p] && loop[p]) begin
          if (!full[p]) begin
            fifo[p][wp[p]] <= wdata;
            wp[p] <= wp_nx[p];
            if (wp_nx[p] == rp[p]) full[p] <= 1'b1;
          end
          rxrdy[p]  <= 1'b1;
          isr_rx[p] <= 1'b1;
        end
        if (pop[p]) begin
          rp[p] <= rp_nx[p];
          if (last[p]) begin
            rxrdy[p]  <= 1'b0;
            full[p]   <= 1'b0;
            isr_rx[p] <= 1'b0;
          end
        end
        if (wr_cmd[p] && wdata[4]) drq[p] <= 1'b1;
        if (en[p]) begin
          txen[p]  <= 1'b1;
          txrdy[p] <= 1'b1;
          txemp[p] <= 1'b1;
        end
        if (dis[p]) begin
          txen[p]  <= 1'b0;
          txrdy[p] <= 1'b0;
          txemp[p] <= 1'b0;
          drq[p]   <= 1'b0;
          cnt[p]   <= '0;
        end
      end
      if (we && addr == 4'd8) mask <= wdata;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (re) begin
        case (addr)
          4'd0, 4'd4: rdata <= ctrl[addr[2]];
          4'd1, 4'd5: rdata <= {4'b0, txemp[addr[2]], txrdy[addr[2]], full[addr[2]], rxrdy[addr[2]]};
          4'd2, 4'd6: rdata <= fifo[addr[2]][rp[addr[2]]];
          4'd8:       rdata <= isr_val;
          4'd9:       rdata <= {7'h7f, ~carrier};
          4'd10:      rdata <= mask;
          default:    rdata <= '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    a_r7_full_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[g]) |-> wp[g] == rp[g]);
    a_r4_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
      acc[g] && !loop[g] && !dis[g] |=> !txrdy[g] && !txemp[g]);
    a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd[g] && wdata[3] |=> !txrdy[g] && !txemp[g] && !drq[g] && !txen[g]);
    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dat[g] && !txen[g] |=> $stable(wp[g]) && $stable(rxrdy[g]) && $stable(txrdy[g]));
    a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pop[g] && last[g] && !(acc[g] && loop[g]) |=> !rxrdy[g] && !isr_rx[g] && !full[g]);
  end
endmodule

// File: tb/test_dual_uart_lb.sv
module test_dual_uart_lb;
  localparam int D = 5;
  logic clk = 0, rst_n = 0, we = 0, re = 0, carrier = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic [1:0] drq;
  int checks = 0, errors = 0;

  dual_uart_lb #(.TX_DELAY(D), .FIFO_DEPTH(3)) i_dual_uart_lb (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .carrier(carrier), .rdata(rdata), .irq(irq), .drq(drq));

  always #2 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    re = 1; addr = a;
    @(negedge clk);
    re = 0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd1, v); chk(v, 8'h00, "R1 status A");
    rd(4'd5, v); chk(v, 8'h00, "R1 status B");
    rd(4'd8, v); chk(v, 8'h00, "R1 isr");
    chk({7'b0, irq}, 8'h00, "R1 irq");
    chk({6'b0, drq}, 8'h00, "R1 drq");

    carrier = 1; rd(4'd9, v); chk(v, 8'hFE, "R11 carrier on");
    carrier = 0; rd(4'd9, v); chk(v, 8'hFF, "R11 carrier off");

    wr(4'd2, 8'h33); rd(4'd1, v); chk(v, 8'h00, "R10 normal ignored");
    wr(4'd0, 8'h80); wr(4'd2, 8'h44);
    rd(4'd1, v); chk(v, 8'h00, "R10 loopback ignored status");
    rd(4'd8, v); chk(v, 8'h00, "R10 loopback ignored isr");
    wr(4'd0, 8'h00);

    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [3:0] b;
        logic [7:0] mv;
        b  = 4'(p * 4);
        mv = 8'((m & 1) << (p * 4)) | 8'(((m >> 1) & 1) << (p * 4 + 1));
        wr(4'd8, mv);
        wr(b + 4'd1, 8'h04);
        rd(b + 4'd1, v); chk(v, 8'h0C, "R2 enable");
        wr(b + 4'd2, 8'hA5);
        chk({7'b0, irq}, 8'h00, "R12 irq dropped");
        rd(b + 4'd1, v); chk(v, 8'h00, "R4 busy status");
        rd(4'd8, v); chk({7'b0, v[p*4]}, 8'h00, "R4 isr tx cleared");
        repeat (D - 3) @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R4 delay not yet done");
        @(negedge clk);
        chk({7'b0, irq}, 8'(m & 1), "R5 tx irq by mask");
        rd(b + 4'd1, v); chk(v, 8'h04, "R4 ready after delay");
        rd(4'd8, v); chk({7'b0, v[p*4]}, 8'h01, "R4 isr tx set");

        wr(b, 8'h80);
        for (int k = 0; k < 4; k++) begin
          wr(b + 4'd2, 8'(8'h30 + p * 16 + m * 4 + k));
          if (k == 0) begin
            chk({7'b0, irq}, 8'((m >> 1) & 1), "R6 loopback irq by mask");
            rd(b + 4'd1, v); chk(v, 8'h05, "R6 loopback status");
            rd(4'd8, v); chk({7'b0, v[p*4+1]}, 8'h01, "R6 isr rx set");
          end
          if (k == 2) begin
            rd(b + 4'd1, v); chk(v, 8'h07, "R7 full after three");
          end
        end
        for (int k = 0; k < 3; k++) begin
          rd(b + 4'd2, v); chk(v, 8'(8'h30 + p * 16 + m * 4 + k), "R8 fifo order");
          chk({7'b0, irq}, (k < 2) ? 8'h01 : 8'h00, "R9 irq after read");
          rd(b + 4'd1, v); chk(v, (k < 2) ? 8'h07 : 8'h04, "R7 R9 status after read");
        end
        rd(4'd8, v); chk({7'b0, v[p*4+1]}, 8'h00, "R9 isr rx cleared");
        wr(b, 8'h00);
        wr(b + 4'd1, 8'h10); chk({7'b0, drq[p]}, 8'h01, "R3 drq raised");
        wr(b + 4'd1, 8'h0C); chk({7'b0, drq[p]}, 8'h00, "R3 drq cleared");
        rd(b + 4'd1, v); chk(v, 8'h00, "R3 disable status");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule